// File: doc/BRIEF.md
# Source-Routed Two-Way Packet Steering Unit

This block sits at a branch point of an on-chip packet network and sends each arriving packet to one of two downstream links. A packet is a variable-length run of symbols: one leading routing symbol, any number of body symbols, and a final symbol marked as end of packet. The sender works out the path in advance and places it in the routing symbol. The network topology is therefore never computed here.

While no route is held, the unit takes the next symbol as the route selector. It latches the selected output and drops that symbol, so the next hop finds its own routing symbol at the head of what it receives. Body symbols and the closing end-of-packet symbol then pass, in order, to the latched output through a one-entry register stage with a valid/acknowledge handshake. Once the end-of-packet symbol has been accepted, the route is released and the next symbol is treated as a new route selector. Only the route setup costs a cycle. Every later symbol moves at one per clock while the downstream side acknowledges.

Top module: `pkt_steer2`

## Requirements
- R1: After reset both output valids are low and `in_ack` is high, because the unit waits for a routing symbol.
- R2: The symbol accepted while no route is held is consumed as the route selector and never appears on either output.
- R3: A routing symbol whose data value is 0 selects output 0. Any other value (1, 2 or 3) selects output 1.
- R4: Each symbol accepted while a route is held appears exactly once, with data and end flag unchanged and in arrival order, on the selected output only. The other output stays idle.
- R5: The end-of-packet symbol (`in_eop` = 1) is forwarded to the selected output with its end flag set. The route is then released, so the next symbol accepted is a new route selector.
- R6: A packet made of only a routing symbol and an end-of-packet symbol forwards just that one end-of-packet symbol.
- R7: While an output holds a symbol that is not acknowledged, its valid, data and end flag stay unchanged. While that output is the selected one, `in_ack` is low.
- R8: With the selected output acknowledging every cycle, body symbols are accepted on back-to-back cycles with no stall.
- R9: An end-of-packet symbol that arrives while no route is held is consumed and dropped. It leaves the unit without a route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input symbol valid |
| in_ack | output | 1 | Input symbol accepted when high together with `in_vld` |
| in_eop | input | 1 | Input symbol is end of packet |
| in_dat | input | DW | Input symbol data value |
| out_vld | output | 2 | Per-output symbol valid (bit i for output i) |
| out_ack | input | 2 | Per-output acknowledge from downstream |
| out_eop | output | 2 | Per-output end-of-packet flag |
| out_dat | output | 2×DW | Per-output symbol data, entry i for output i |

## Verification
A route bit that is stuck or set late sends the whole next packet to the wrong output. This shows on the very first body symbol, one cycle after it is accepted. A route that is not released at end of packet makes the following routing symbol leak onto an output as data, and that also shows one cycle after acceptance. A wrongly released route has the opposite effect: the next body symbol vanishes as if it were a selector. Flow-control faults show as a held output changing under a low acknowledge, or as `in_ack` staying high while the selected output is full, which loses a symbol within the same cycle.

// File: rtl/steer_pkg.sv
package steer_pkg;
    localparam int NUM_OUT = 2;
    localparam int SEL_W   = 1;

    typedef struct packed {
        logic on;
        logic sel;
    } route_st_t;
endpackage

// File: rtl/steer_route_ctl.sv
module steer_route_ctl
    import steer_pkg::*;
#(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          sym_eop,
    input  logic [DW-1:0] sym_dat,
    output logic          route_on,
    output logic          route_sel
);
    route_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc) begin
            if (!st_q.on) begin
                // a stray end marker with no route is simply dropped
                if (!sym_eop) begin
                    st_d.on  = 1'b1;
                    st_d.sel = (sym_dat != '0);
                end
            end else if (sym_eop) begin
                st_d.on = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign route_on  = st_q.on;
    assign route_sel = st_q.sel;

    // R5: accepted end marker under a route releases it
    a_r5_teardown: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && route_on && sym_eop) |=> !route_on);

    // R2, R3: selector symbol arms the route toward the encoded output
    a_r3_route_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !route_on && !sym_eop) |=> (route_on && (route_sel == $past(sym_dat != '0))));

    // R9: end marker while idle leaves no route
    a_r9_stray_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !route_on && sym_eop) |=> !route_on);
endmodule

// File: rtl/steer_out_reg.sv
module steer_out_reg #(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          ld_eop,
    input  logic [DW-1:0] ld_dat,
    input  logic          ack,
    output logic          room,
    output logic          vld,
    output logic          eop,
    output logic [DW-1:0] dat
);
    typedef struct packed {
        logic          vld;
        logic          eop;
        logic [DW-1:0] dat;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.vld = 1'b1;
            s_d.eop = ld_eop;
            s_d.dat = ld_dat;
        end else if (ack) begin
            s_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign room = !s_q.vld || ack;
    assign vld  = s_q.vld;
    assign eop  = s_q.eop;
    assign dat  = s_q.dat;

    // R7: unacknowledged content is held
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !ack) |=> (vld && $stable(eop) && $stable(dat)));

    // R7: never overwrite a symbol still waiting
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!vld || ack));
endmodule

// File: rtl/pkt_steer2.sv
module pkt_steer2
    import steer_pkg::*;
#(
    parameter int DW = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    output logic                         in_ack,
    input  logic                         in_eop,
    input  logic [DW-1:0]                in_dat,
    output logic [NUM_OUT-1:0]           out_vld,
    input  logic [NUM_OUT-1:0]           out_ack,
    output logic [NUM_OUT-1:0]           out_eop,
    output logic [NUM_OUT-1:0][DW-1:0]   out_dat
);
    logic               route_on;
    logic               route_sel;
    logic               acc;
    logic               fwd;
    logic [NUM_OUT-1:0] room;
    logic [NUM_OUT-1:0] load;

    steer_route_ctl #(.DW(DW)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .sym_eop   (in_eop),
        .sym_dat   (in_dat),
        .route_on  (route_on),
        .route_sel (route_sel)
    );

    // selector symbols are always taken; others wait for space downstream
    assign in_ack = route_on ? room[route_sel] : 1'b1;
    assign acc    = in_vld && in_ack;
    assign fwd    = acc && route_on;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        assign load[g] = fwd && (route_sel == SEL_W'(g));

        steer_out_reg #(.DW(DW)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load[g]),
            .ld_eop (in_eop),
            .ld_dat (in_dat),
            .ack    (out_ack[g]),
            .room   (room[g]),
            .vld    (out_vld[g]),
            .eop    (out_eop[g]),
            .dat    (out_dat[g])
        );
    end

    // R4: a symbol lands in one output at most
    a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));

    // R2: consuming a selector never raises an idle output
    a_r2_selector_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !route_on && out_vld == '0) |=> (out_vld == '0));
endmodule

// File: tb/tb_pkt_steer2.sv
module tb_pkt_steer2;
    localparam int DW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_vld = 1'b0;
    logic               in_ack;
    logic               in_eop = 1'b0;
    logic [DW-1:0]      in_dat = '0;
    logic [1:0]         out_vld;
    logic [1:0]         out_ack = 2'b11;
    logic [1:0]         out_eop;
    logic [1:0][DW-1:0] out_dat;

    int n_chk = 0;
    int n_fail = 0;
    int stalls = 0;
    bit done = 1'b0;

    logic [2:0] rec [2][64];
    int nrec [2];

    always #4 clk = ~clk;

    pkt_steer2 #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ack(in_ack),
        .in_eop(in_eop), .in_dat(in_dat), .out_vld(out_vld),
        .out_ack(out_ack), .out_eop(out_eop), .out_dat(out_dat)
    );

    // record completed output transfers just before each rising edge
    always @(negedge clk) begin
        #3;
        for (int p = 0; p < 2; p++) begin
            if (rst_n && out_vld[p] && out_ack[p] && nrec[p] < 64) begin
                rec[p][nrec[p]] = {out_eop[p], out_dat[p]};
                nrec[p]++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_rec();
        nrec[0] = 0;
        nrec[1] = 0;
    endtask

    // present a symbol at a falling edge and hold it until accepted
    task automatic send(input bit eop, input int d);
        @(negedge clk);
        in_vld = 1'b1;
        in_eop = eop;
        in_dat = DW'(d);
        #1;
        while (!in_ack) begin
            @(negedge clk);
            #1;
            stalls++;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_vld = 1'b0;
        in_eop = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_sym(input int p, input int idx, input bit eop, input int d, input string req);
        logic [2:0] e;
        e = {eop, 2'(d)};
        if (idx < nrec[p]) chk(rec[p][idx] == e, req, int'(rec[p][idx]), int'(e));
        else chk(1'b0, req, -1, int'(e));
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(out_vld == 2'b00, "R1 out_vld", int'(out_vld), 0);
        chk(in_ack == 1'b1, "R1 in_ack", int'(in_ack), 1);
    endtask

    task automatic t_port0();
        clear_rec();
        send(0, 0); send(0, 1); send(0, 2); send(0, 3); send(1, 0);
        idle(3);
        chk(nrec[0] == 4, "R2 port0 count", nrec[0], 4);
        chk(nrec[1] == 0, "R4 port1 idle", nrec[1], 0);
        exp_sym(0, 0, 0, 1, "R3 port0 first");
        exp_sym(0, 1, 0, 2, "R4 order");
        exp_sym(0, 2, 0, 3, "R4 order");
        exp_sym(0, 3, 1, 0, "R5 eop forwarded");
    endtask

    task automatic t_port1();
        clear_rec();
        send(0, 2); send(0, 3); send(0, 0); send(1, 1);
        // route released: this selector 1 must not leak as data
        send(0, 1); send(0, 2); send(1, 2);
        idle(3);
        chk(nrec[0] == 0, "R4 port0 idle", nrec[0], 0);
        chk(nrec[1] == 5, "R5 port1 count", nrec[1], 5);
        exp_sym(1, 0, 0, 3, "R3 value 2 to port1");
        exp_sym(1, 1, 0, 0, "R4 data kept");
        exp_sym(1, 2, 1, 1, "R5 eop");
        exp_sym(1, 3, 0, 2, "R5 new route");
        exp_sym(1, 4, 1, 2, "R5 second eop");
    endtask

    task automatic t_short();
        clear_rec();
        send(0, 3); send(1, 0);
        idle(3);
        chk(nrec[1] == 1, "R6 only eop", nrec[1], 1);
        chk(nrec[0] == 0, "R6 port0 idle", nrec[0], 0);
        exp_sym(1, 0, 1, 0, "R6 eop");
    endtask

    task automatic t_stray_eop();
        clear_rec();
        send(1, 1);
        // next symbol must still be taken as a selector
        send(0, 0); send(0, 1); send(1, 3);
        idle(3);
        chk(nrec[0] == 2, "R9 count", nrec[0], 2);
        chk(nrec[1] == 0, "R9 port1 idle", nrec[1], 0);
        exp_sym(0, 0, 0, 1, "R9 body");
        exp_sym(0, 1, 1, 3, "R9 eop");
    endtask

    task automatic t_backpressure();
        clear_rec();
        out_ack[0] = 1'b0;
        send(0, 0); send(0, 1);
        @(negedge clk);
        in_vld = 1'b1; in_eop = 1'b0; in_dat = 2'd2;
        #1;
        chk(in_ack == 1'b0, "R7 in_ack low", int'(in_ack), 0);
        chk(out_vld[0] == 1'b1 && out_dat[0] == 2'd1, "R7 held", int'(out_dat[0]), 1);
        repeat (3) @(negedge clk);
        #1;
        chk(out_vld[0] == 1'b1 && out_dat[0] == 2'd1 && out_eop[0] == 1'b0,
            "R7 stable", int'(out_dat[0]), 1);
        chk(in_ack == 1'b0, "R7 still stalled", int'(in_ack), 0);
        out_ack[0] = 1'b1;
        #1;
        chk(in_ack == 1'b1, "R7 released", int'(in_ack), 1);
        @(posedge clk);
        send(1, 0);
        idle(3);
        chk(nrec[0] == 3, "R7 count", nrec[0], 3);
        exp_sym(0, 0, 0, 1, "R7 first");
        exp_sym(0, 1, 0, 2, "R7 second");
        exp_sym(0, 2, 1, 0, "R7 eop");
    endtask

    task automatic t_throughput();
        clear_rec();
        send(0, 1);
        stalls = 0;
        for (int k = 0; k < 8; k++) send(0, k % 4);
        send(1, 3);
        idle(3);
        chk(stalls == 0, "R8 no stall", stalls, 0);
        chk(nrec[1] == 9, "R8 count", nrec[1], 9);
        exp_sym(1, 7, 0, 3, "R8 last body");
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_rec();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_port0();
        t_port1();
        t_short();
        t_stray_eop();
        t_backpressure();
        t_throughput();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule